// File: doc/BRIEF.md
# Write-Through Store Queue with Read Bypass

This block sits between a write-through cache and the next memory level. The cache hands it stores (address and data) and it keeps them in a small in-order queue, so a single store never waits for memory. The queue retires stores to memory one at a time, oldest first. It has several slots rather than one register, so a burst of back-to-back stores is absorbed.

Read misses bound for memory also pass through the block, which guards against read-after-write hazards. Two hazard modes are selected by a plain input. In check mode every read address is compared against all queued stores. On a match the read is answered from the newest matching store and memory is never asked. With no match the read is sent to memory ahead of the older stores still queued. In drain mode a read is held off until the queue is empty and is then sent to memory.

The store, read and response channels use valid/ready. A source holds its valid and payload until ready is seen high at a clock edge. The store channel drops ready while all slots are occupied. The read channel drops ready while a memory read is in flight, and in drain mode also while the queue holds stores. The memory request channel waits on `mem_req_ready`. A stalled store request may be replaced by a read request, but a store request that is shown again keeps its address and data. Responses carry no ready and must be taken when valid.

Top module: `wt_write_buffer`

## Requirements
- R1: After reset the queue is empty: `wr_ready`=1, `rd_ready`=1, `mem_req_valid`=0 and `rd_resp_valid`=0.
- R2: The queue holds DEPTH (default 4) stores. `wr_ready` is 0 exactly while all slots are occupied.
- R3: Stores reach memory in arrival order with `mem_req_write`=1, one per request handshake, and carry their address and data. A stalled store request that is shown again keeps the same address and data.
- R4: A store whose address equals that of a queued entry other than the oldest one overwrites that entry's data and takes no new slot. A store matching only the oldest entry takes a new slot.
- R5: In check mode (`cfg_drain_mode`=0), a read whose address matches queued stores is answered with the data of the most recently accepted matching store. `rd_resp_valid` rises in the cycle after the read is accepted, and no memory read is issued.
- R6: In check mode, a read with no match is sent to memory (`mem_req_write`=0) even while older stores are still queued.
- R7: In drain mode (`cfg_drain_mode`=1), `rd_ready` stays 0 while any store is queued. The read reaches memory only after every earlier store has.
- R8: A memory read's data is presented on `rd_resp_data`, with `rd_resp_valid`=1, in the cycle after `mem_rsp_valid`.
- R9: A read and a store accepted in the same cycle are ordered read first: the read does not see that store.
- R10: While a memory-bound read is in flight, `rd_ready` stays 0 until its response has been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_drain_mode | input | 1 | 1 = drain queue before reads, 0 = check and bypass |
| wr_valid | input | 1 | Store request valid |
| wr_ready | output | 1 | Store slot available |
| wr_addr | input | ADDR_W | Store address |
| wr_data | input | DATA_W | Store data |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted |
| rd_addr | input | ADDR_W | Read address |
| rd_resp_valid | output | 1 | Read data valid (one cycle) |
| rd_resp_data | output | DATA_W | Read data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 = store, 0 = read |
| mem_req_addr | output | ADDR_W | Memory request address |
| mem_req_wdata | output | DATA_W | Store data to memory |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | DATA_W | Memory read data |

## Verification
Reads are tried against a queue holding duplicate addresses, one of them merged and one not. This separates newest-match forwarding from oldest-match forwarding and shows whether a merge consumed a slot. Reads that miss are issued while store retirement is stalled, which separates read-first bypass from in-order service. Drain mode is tried with stores queued to the read's own address, which distinguishes waiting for an empty queue from forwarding. A read and a store to the same address in one cycle expose the ordering inside a cycle.

// File: rtl/wtb_pkg.sv
package wtb_pkg;
  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_ISSUE = 2'd1,
    RD_WAIT  = 2'd2
  } rd_state_e;
endpackage

// File: rtl/wtb_store.sv
// Circular store queue with a merge search on insert and a newest-match lookup.
// DEPTH must be a power of two so slot pointers wrap naturally.
module wtb_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              empty,
  output logic              full,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  output logic              look_hit,
  output logic [DATA_W-1:0] look_data,
  output logic [CNT_W-1:0]  count
);
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]  head_q;
  logic [CNT_W-1:0]  cnt_q;

  logic [PTR_W-1:0]  slot_of [DEPTH];
  logic              live    [DEPTH];

  // age k = 0 is the oldest entry
  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    assign slot_of[k] = head_q + PTR_W'(k);
    assign live[k]    = (CNT_W'(k) < cnt_q);
  end

  logic              merge_hit;
  logic [PTR_W-1:0]  merge_slot;
  logic [PTR_W-1:0]  tail_slot;

  always_comb begin
    merge_hit  = 1'b0;
    merge_slot = '0;
    for (int k = 1; k < DEPTH; k++) begin
      if (live[k] && addr_q[slot_of[k]] == push_addr) begin
        merge_hit  = 1'b1;
        merge_slot = slot_of[k];
      end
    end
  end

  always_comb begin
    look_hit  = 1'b0;
    look_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (live[k] && addr_q[slot_of[k]] == look_addr) begin
        look_hit  = 1'b1;
        look_data = data_q[slot_of[k]];
      end
    end
  end

  assign tail_slot = head_q + PTR_W'(cnt_q);
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign head_addr = addr_q[head_q];
  assign head_data = data_q[head_q];
  assign count     = cnt_q;

  logic grow;
  assign grow = push && !merge_hit;

  always_ff @(posedge clk) begin
    if (push) begin
      if (merge_hit) begin
        data_q[merge_slot] <= push_data;
      end else begin
        addr_q[tail_slot] <= push_addr;
        data_q[tail_slot] <= push_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop) head_q <= head_q + PTR_W'(1);
      cnt_q <= cnt_q + CNT_W'(grow) - CNT_W'(pop);
    end
  end
endmodule

// File: rtl/wtb_rd_ctrl.sv
// Read path: forwards from the queue or runs one memory read at a time.
module wtb_rd_ctrl
  import wtb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_drain,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_ready,
  input  logic              buf_empty,
  input  logic              look_hit,
  input  logic [DATA_W-1:0] look_data,
  input  logic              mem_grant,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              rd_issue,
  output logic [ADDR_W-1:0] rd_issue_addr,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data
);
  rd_state_e         state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_fire;
  logic              fwd;

  assign rd_ready      = (state_q == RD_IDLE) && !(cfg_drain && !buf_empty);
  assign rd_fire       = rd_valid && rd_ready;
  assign fwd           = rd_fire && !cfg_drain && look_hit;
  assign rd_issue      = (state_q == RD_ISSUE);
  assign rd_issue_addr = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= RD_IDLE;
      addr_q     <= '0;
      resp_valid <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (state_q)
        RD_IDLE: begin
          if (fwd) begin
            resp_valid <= 1'b1;
            resp_data  <= look_data;
          end else if (rd_fire) begin
            addr_q  <= rd_addr;
            state_q <= RD_ISSUE;
          end
        end
        RD_ISSUE: if (mem_grant) state_q <= RD_WAIT;
        RD_WAIT: begin
          if (mem_rsp_valid) begin
            resp_valid <= 1'b1;
            resp_data  <= mem_rsp_data;
            state_q    <= RD_IDLE;
          end
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wt_write_buffer.sv
module wt_write_buffer #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_drain_mode,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_resp_valid,
  output logic [DATA_W-1:0] rd_resp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              buf_empty, buf_full, look_hit, push, pop, rd_issue;
  logic [ADDR_W-1:0] head_addr, rd_issue_addr;
  logic [DATA_W-1:0] head_data, look_data;
  logic [CNT_W-1:0]  occupancy;

  assign wr_ready = !buf_full;
  assign push     = wr_valid && wr_ready;

  // a pending read outranks queued stores on the memory port
  assign mem_req_valid = rd_issue || !buf_empty;
  assign mem_req_write = !rd_issue;
  assign mem_req_addr  = rd_issue ? rd_issue_addr : head_addr;
  assign mem_req_wdata = head_data;
  assign pop           = mem_req_valid && mem_req_ready && !rd_issue;

  wtb_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_addr (wr_addr),
    .push_data (wr_data),
    .pop       (pop),
    .look_addr (rd_addr),
    .empty     (buf_empty),
    .full      (buf_full),
    .head_addr (head_addr),
    .head_data (head_data),
    .look_hit  (look_hit),
    .look_data (look_data),
    .count     (occupancy)
  );

  wtb_rd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_drain     (cfg_drain_mode),
    .rd_valid      (rd_valid),
    .rd_addr       (rd_addr),
    .rd_ready      (rd_ready),
    .buf_empty     (buf_empty),
    .look_hit      (look_hit),
    .look_data     (look_data),
    .mem_grant     (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .rd_issue      (rd_issue),
    .rd_issue_addr (rd_issue_addr),
    .resp_valid    (rd_resp_valid),
    .resp_data     (rd_resp_data)
  );
endmodule

// File: rtl/wt_write_buffer_chk.sv
module wt_write_buffer_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_drain_mode,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic              rd_resp_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [DATA_W-1:0] mem_req_wdata,
  input logic              mem_rsp_valid,
  input logic              look_hit,
  input logic [CNT_W-1:0]  occupancy
);
  // R2
  a_r2_occupancy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= CNT_W'(DEPTH));

  // R3
  a_r3_store_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write && !mem_req_ready) |=>
      (!mem_req_write || ($stable(mem_req_addr) && $stable(mem_req_wdata))));

  // R5
  a_r5_forward_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && !cfg_drain_mode && look_hit) |=> rd_resp_valid);

  // R5
  a_r5_forward_no_memread: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && !cfg_drain_mode && look_hit) |=>
      !(mem_req_valid && !mem_req_write));

  // R7
  a_r7_drain_before_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_drain_mode && rd_valid && rd_ready) |-> !(mem_req_valid && mem_req_write));

  // R8
  a_r8_rsp_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |=> rd_resp_valid);
endmodule

bind wt_write_buffer wt_write_buffer_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_drain_mode (cfg_drain_mode),
  .rd_valid       (rd_valid),
  .rd_ready       (rd_ready),
  .rd_resp_valid  (rd_resp_valid),
  .mem_req_valid  (mem_req_valid),
  .mem_req_ready  (mem_req_ready),
  .mem_req_write  (mem_req_write),
  .mem_req_addr   (mem_req_addr),
  .mem_req_wdata  (mem_req_wdata),
  .mem_rsp_valid  (mem_rsp_valid),
  .look_hit       (look_hit),
  .occupancy      (occupancy)
);

// File: tb/wt_write_buffer_bench.sv
module wt_write_buffer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_drain_mode = 1'b0;
  logic        wr_valid = 1'b0, rd_valid = 1'b0;
  logic        wr_ready, rd_ready, rd_resp_valid;
  logic [7:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_resp_data;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [7:0]  mem_req_addr;
  logic [15:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic [15:0] mem_rsp_data;
  logic        stall_w = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wt_write_buffer u_wt_write_buffer (.*);

  // memory model: stores can be stalled, reads are always taken
  assign mem_req_ready = !(stall_w && mem_req_write);

  logic [15:0] mem_arr [256];
  logic [7:0]  wlog_a [32];
  logic [15:0] wlog_d [32];
  int          wcount, rcount, wcount_at_read;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem_arr[i] <= {8'h5A, 8'(i)};
      wcount <= 0; rcount <= 0; wcount_at_read <= 0;
      mem_rsp_valid <= 1'b0; mem_rsp_data <= '0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          mem_arr[mem_req_addr] <= mem_req_wdata;
          if (wcount < 32) begin
            wlog_a[wcount] <= mem_req_addr;
            wlog_d[wcount] <= mem_req_wdata;
          end
          wcount <= wcount + 1;
        end else begin
          mem_rsp_valid  <= 1'b1;
          mem_rsp_data   <= mem_arr[mem_req_addr];
          rcount         <= rcount + 1;
          wcount_at_read <= wcount;
        end
      end
    end
  end

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_addr = a; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [15:0] d,
                         output int lat, output logic rdy_after);
    @(negedge clk); rd_valid = 1'b1; rd_addr = a;
    while (!rd_ready) @(negedge clk);
    @(negedge clk); rd_valid = 1'b0; lat = 1; rdy_after = rd_ready;
    while (!rd_resp_valid && lat < 50) begin @(negedge clk); lat++; end
    d = rd_resp_data;
  endtask

  task automatic wait_writes(input int n);
    for (int i = 0; i < 200 && wcount < n; i++) @(negedge clk);
  endtask

  // rows: address, expected data, expected forwarded
  localparam logic [32:0] RD_TABLE [5] = '{
    {8'h10, 16'h3333, 1'b1, 8'h00},
    {8'h20, 16'h4444, 1'b1, 8'h00},
    {8'h60, 16'h6666, 1'b1, 8'h00},
    {8'h30, 16'h5A30, 1'b0, 8'h00},
    {8'h11, 16'h5A11, 1'b0, 8'h00}
  };

  initial begin
    logic [15:0] d;
    int          lat;
    logic        ra;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 wr_ready", wr_ready, 1);
    chk("R1 rd_ready", rd_ready, 1);
    chk("R1 mem_req_valid", mem_req_valid, 0);
    chk("R1 rd_resp_valid", rd_resp_valid, 0);

    // fill with duplicates while stores are stalled
    stall_w = 1'b1;
    do_write(8'h10, 16'h1111);
    do_write(8'h20, 16'h2222);
    do_write(8'h10, 16'h3333); // matches only the oldest: new slot
    do_write(8'h20, 16'h4444); // merges into the 0x20 entry
    chk("R4 merge took no slot", wr_ready, 1);
    do_write(8'h60, 16'h6666);
    chk("R2 full drops wr_ready", wr_ready, 0);

    for (int r = 0; r < 5; r++) begin
      logic [7:0]  ta;
      logic [15:0] td;
      logic        tf;
      ta = RD_TABLE[r][32:25];
      td = RD_TABLE[r][24:9];
      tf = RD_TABLE[r][8];
      do_read(ta, d, lat, ra);
      chk(tf ? "R5 newest match data" : "R6 bypass read data", d, td);
      chk(tf ? "R5 forward latency" : "R6 read went to memory", (lat == 1), tf);
      if (!tf) begin
        chk("R6 read ahead of queued stores", wcount_at_read, 0);
        chk("R10 rd_ready low while in flight", ra, 0);
      end
    end
    chk("R5 no memory read on forward", rcount, 2);

    stall_w = 1'b0;
    wait_writes(4);
    chk("R3 store count", wcount, 4);
    chk("R3 order 0", {wlog_a[0], wlog_d[0]}, {8'h10, 16'h1111});
    chk("R3 order 1", {wlog_a[1], wlog_d[1]}, {8'h20, 16'h4444});
    chk("R3 order 2", {wlog_a[2], wlog_d[2]}, {8'h10, 16'h3333});
    chk("R3 order 3", {wlog_a[3], wlog_d[3]}, {8'h60, 16'h6666});
    do_read(8'h10, d, lat, ra);
    chk("R8 memory holds newest store", d, 16'h3333);
    chk("R8 memory read latency", lat, 3);

    // drain mode
    stall_w = 1'b1;
    cfg_drain_mode = 1'b1;
    do_write(8'h40, 16'hBEEF);
    do_write(8'h41, 16'hCAFE);
    @(negedge clk); rd_valid = 1'b1; rd_addr = 8'h40;
    repeat (3) @(negedge clk);
    chk("R7 rd_ready low with queued stores", rd_ready, 0);
    stall_w = 1'b0;
    for (int i = 0; i < 50 && !rd_ready; i++) @(negedge clk);
    @(negedge clk); rd_valid = 1'b0; lat = 1;
    while (!rd_resp_valid && lat < 50) begin @(negedge clk); lat++; end
    chk("R7 read data after drain", rd_resp_data, 16'hBEEF);
    chk("R7 stores reached memory first", wcount_at_read, 6);
    chk("R7 not forwarded", (lat == 1), 0);

    // same-cycle read and store to one address
    cfg_drain_mode = 1'b0;
    stall_w = 1'b1;
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 8'h50; wr_data = 16'h7777;
    rd_valid = 1'b1; rd_addr = 8'h50;
    @(negedge clk);
    wr_valid = 1'b0; rd_valid = 1'b0; lat = 1;
    while (!rd_resp_valid && lat < 50) begin @(negedge clk); lat++; end
    chk("R9 read ordered before store", rd_resp_data, 16'h5A50);
    do_read(8'h50, d, lat, ra);
    chk("R9 later read forwards", d, 16'h7777);
    chk("R5 later read latency", lat, 1);
    stall_w = 1'b0;
    wait_writes(7);
    chk("R3 final store count", wcount, 7);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule